// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches eight general-purpose input lines and turns activity on them into one interrupt request. Each line can be set to level or edge sensing. In level mode its status follows the input and needs no acknowledge. In edge mode it latches an event on a rising edge, a falling edge or either edge, and the latch holds until software clears it. All configuration and status sits in byte-wide registers, one bit per line, reached through a plain valid/write/address/data port. Reads return data combinationally in the same cycle.

Every input passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Each line has a small state machine with two states. `LN_QUIET` means no edge event is latched. `LN_HELD` means an edge event is latched. The transitions are:
- `QUIET->HELD` on an edge event while the line is edge-sensed.
- `HELD->QUIET` on a clear write to that line when no new event occurs in the same cycle.
- `HELD->QUIET` when the line is switched to level sensing.
- `HELD->HELD` when an event and a clear occur together.

Raw status is ANDed with a mask, and the OR of the masked bits drives the interrupt output.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the registers at addresses 1 to 7 read 0 and `irq_out` is 0.
- R2: Addresses 1 (sense, 1 = level), 2 (both edges), 3 (polarity) and 4 (mask) read back the last byte written. Address 0 reads the synchronised inputs two clocks after a pin change. Address 7 is write-only and reads 0.
- R3: With its sense bit at 1, a line's raw status (address 5) is 1 exactly when the synchronised input equals its polarity bit (1 = high, 0 = low). The bit drops with no clear write.
- R4: With sense 0 and both-edges 0, a line latches raw status on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The status is visible after the third clock edge following the pin change, and it holds after the input returns.
- R5: Writing address 7 clears the latched edge status of each line whose data bit is 1. Bits written as 0 leave status unchanged.
- R6: Masked status (address 6) equals raw status ANDed with the mask. `irq_out` is 1 exactly when masked status is nonzero.
- R7: With both-edges at 1, an edge-sensed line latches on both rising and falling edges, whatever its polarity bit.
- R8: With sense, both-edges, polarity and mask all 0, input activity never raises `irq_out`.
- R9: If an edge event and a clear write for the same line occur in the same cycle, the status stays set.
- R10: Switching a line from edge to level sensing discards its latched event, so switching back shows no stale status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 8 | Asynchronous input lines |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume each bus cycle carries a single access, so a clear write never coincides with a write to the sense register. The clear and event-wins properties rely on this, because sensing mode cannot change under them. The bench issues at most one access per cycle. It starts from reset with the inputs held low, so no spurious edge appears when the synchroniser leaves reset. It times the clear write for the event-wins case to land on the cycle in which the synchronised edge is present.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int LINES_DEF  = 8;
    localparam int ADDR_W_DEF = 3;

    typedef enum logic [2:0] {
        REG_DIN    = 3'd0,
        REG_SENSE  = 3'd1,
        REG_BOTH   = 3'd2,
        REG_POL    = 3'd3,
        REG_MASK   = 3'd4,
        REG_RAW    = 3'd5,
        REG_MASKED = 3'd6,
        REG_CLEAR  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LN_QUIET = 1'b0,
        LN_HELD  = 1'b1
    } line_state_e;

endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LAST];
endmodule

// File: rtl/gis_line.sv
module gis_line
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_v,
    input  logic cfg_level,
    input  logic cfg_both,
    input  logic cfg_pol,
    input  logic clr_bit,
    output logic raw_bit,
    output logic event_bit
);
    line_state_e state_q, state_d;
    logic        prev_q;
    logic        rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_v;
    end

    assign rise = sync_v & ~prev_q;
    assign fall = ~sync_v & prev_q;

    always_comb begin
        if (cfg_level)     event_bit = 1'b0;
        else if (cfg_both) event_bit = rise | fall;
        else if (cfg_pol)  event_bit = rise;
        else               event_bit = fall;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_QUIET: if (event_bit) state_d = LN_HELD;
            LN_HELD: begin
                if (cfg_level)      state_d = LN_QUIET;
                else if (event_bit) state_d = LN_HELD;
                else if (clr_bit)   state_d = LN_QUIET;
            end
            default: state_d = LN_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        if (cfg_level) raw_bit = (sync_v == cfg_pol);
        else           raw_bit = (state_q == LN_HELD);
    end
endmodule

// File: rtl/gis_regfile.sv
module gis_regfile
    import gpio_irq_pkg::*;
#(
    parameter int LINES  = LINES_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic [LINES-1:0]  din,
    input  logic [LINES-1:0]  raw,
    input  logic [LINES-1:0]  masked,
    output logic [LINES-1:0]  cfg_sense,
    output logic [LINES-1:0]  cfg_both,
    output logic [LINES-1:0]  cfg_pol,
    output logic [LINES-1:0]  cfg_mask,
    output logic [LINES-1:0]  clr_vec,
    output logic [LINES-1:0]  bus_rdata
);
    reg_addr_e sel;
    logic      wr;

    assign sel = reg_addr_e'(bus_addr);
    assign wr  = bus_valid & bus_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sense <= '0;
            cfg_both  <= '0;
            cfg_pol   <= '0;
            cfg_mask  <= '0;
        end else if (wr) begin
            unique case (sel)
                REG_SENSE: cfg_sense <= bus_wdata;
                REG_BOTH:  cfg_both  <= bus_wdata;
                REG_POL:   cfg_pol   <= bus_wdata;
                REG_MASK:  cfg_mask  <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr && sel == REG_CLEAR) ? bus_wdata : '0;

    always_comb begin
        unique case (sel)
            REG_DIN:    bus_rdata = din;
            REG_SENSE:  bus_rdata = cfg_sense;
            REG_BOTH:   bus_rdata = cfg_both;
            REG_POL:    bus_rdata = cfg_pol;
            REG_MASK:   bus_rdata = cfg_mask;
            REG_RAW:    bus_rdata = raw;
            REG_MASKED: bus_rdata = masked;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gpio_irq_pkg::*;
#(
    parameter int LINES       = LINES_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  gpio_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              irq_out
);
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] cfg_sense, cfg_both, cfg_pol, cfg_mask;
    logic [LINES-1:0] clr_vec, raw_stat, masked_stat, line_ev;

    gis_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_in),
        .dout (sync_q)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        gis_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_v   (sync_q[g]),
            .cfg_level(cfg_sense[g]),
            .cfg_both (cfg_both[g]),
            .cfg_pol  (cfg_pol[g]),
            .clr_bit  (clr_vec[g]),
            .raw_bit  (raw_stat[g]),
            .event_bit(line_ev[g])
        );
    end

    assign masked_stat = raw_stat & cfg_mask;
    assign irq_out     = |masked_stat;

    gis_regfile #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .din      (sync_q),
        .raw      (raw_stat),
        .masked   (masked_stat),
        .cfg_sense(cfg_sense),
        .cfg_both (cfg_both),
        .cfg_pol  (cfg_pol),
        .cfg_mask (cfg_mask),
        .clr_vec  (clr_vec),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_rdata,
    input logic              irq_out,
    input logic [LINES-1:0]  raw_stat,
    input logic [LINES-1:0]  cfg_sense,
    input logic [LINES-1:0]  cfg_mask,
    input logic [LINES-1:0]  clr_vec,
    input logic [LINES-1:0]  line_ev
);
    localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(7);

    logic sense_wr;
    assign sense_wr = bus_valid && bus_write && (bus_addr == A_SENSE);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec != '0) && (cfg_sense == '0) && (line_ev == '0))
        |=> ((raw_stat & $past(clr_vec)) == '0))
        else $error("p_clear_r5");

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_ev != '0) && !sense_wr)
        |=> ((raw_stat & $past(line_ev)) == $past(line_ev)))
        else $error("p_event_wins_r9");

    p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (cfg_mask != '0))
        else $error("p_irq_needs_mask_r6");

    p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == A_CLEAR) |-> (bus_rdata == '0))
        else $error("p_clear_reads_zero_r2");

    p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask == '0) |-> !irq_out)
        else $error("p_irq_low_r8");
endmodule

bind gpio_irq_sense gis_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .raw_stat (raw_stat),
    .cfg_sense(cfg_sense),
    .cfg_mask (cfg_mask),
    .clr_vec  (clr_vec),
    .line_ev  (line_ev)
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gpio_in = '0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #4 clk = ~clk;

    gpio_irq_sense u_gpio_irq_sense (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (rst_n && bus_valid && !bus_write) begin
            tests++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: read addr %0d got %02h exp none", bus_addr, bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (it.addr != bus_addr || bus_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: addr %0d got %02h exp %02h", it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        tests++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s: irq_out got %0b exp %0b", tag, irq_out, e);
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        gpio_in = '0; bus_valid = 0; bus_write = 0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    initial begin
        #(LIMIT * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1 reset state
        for (int a = 1; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 reset reg");
        irq_chk(1'b0, "R1 reset irq");

        // R2 readback and data input
        bus_wr(3'd1, 8'hA5); rd_chk(3'd1, 8'hA5, "R2 sense rb");
        bus_wr(3'd2, 8'h3C); rd_chk(3'd2, 8'h3C, "R2 both rb");
        bus_wr(3'd3, 8'h0F); rd_chk(3'd3, 8'h0F, "R2 pol rb");
        bus_wr(3'd4, 8'hF0); rd_chk(3'd4, 8'hF0, "R2 mask rb");
        bus_wr(3'd7, 8'hFF); rd_chk(3'd7, 8'h00, "R2 clear reads 0");
        do_reset();
        gpio_in = 8'h5A; tick(2);
        rd_chk(3'd0, 8'h5A, "R2 data input");

        // R8 all-zero config, R4 falling latch, R5 clear
        do_reset();
        gpio_in = 8'h01; tick(3);
        gpio_in = 8'h00; tick(3);
        irq_chk(1'b0, "R8 no irq");
        rd_chk(3'd6, 8'h00, "R8 masked zero");
        rd_chk(3'd5, 8'h01, "R4 falling latched");
        bus_wr(3'd7, 8'hFE);
        rd_chk(3'd5, 8'h01, "R5 zero bits no effect");
        bus_wr(3'd7, 8'h01);
        rd_chk(3'd5, 8'h00, "R5 clear");

        // R4 rising, R6 mask/irq
        do_reset();
        bus_wr(3'd3, 8'h02); bus_wr(3'd4, 8'h02);
        gpio_in = 8'h02; tick(3);
        rd_chk(3'd5, 8'h02, "R4 rising latched");
        rd_chk(3'd6, 8'h02, "R6 masked");
        irq_chk(1'b1, "R6 irq high");
        gpio_in = 8'h00; tick(3);
        rd_chk(3'd5, 8'h02, "R4 holds after input drops");
        bus_wr(3'd7, 8'h02);
        irq_chk(1'b0, "R5 irq cleared");

        // R3 level high and low
        do_reset();
        bus_wr(3'd1, 8'h04); bus_wr(3'd3, 8'h04); bus_wr(3'd4, 8'h04);
        gpio_in = 8'h04; tick(3);
        rd_chk(3'd5, 8'h04, "R3 level high active");
        irq_chk(1'b1, "R3 level irq");
        gpio_in = 8'h00; tick(3);
        rd_chk(3'd5, 8'h00, "R3 level drops no clear");
        irq_chk(1'b0, "R3 level irq drops");
        bus_wr(3'd3, 8'h00);
        rd_chk(3'd5, 8'h04, "R3 level low active");
        gpio_in = 8'h04; tick(3);
        rd_chk(3'd5, 8'h00, "R3 level low inactive");

        // R7 both edges, R9 event wins
        do_reset();
        bus_wr(3'd2, 8'h08); bus_wr(3'd3, 8'h08); bus_wr(3'd4, 8'h08);
        gpio_in = 8'h08; tick(3);
        rd_chk(3'd5, 8'h08, "R7 rise");
        bus_wr(3'd7, 8'h08);
        rd_chk(3'd5, 8'h00, "R7 cleared");
        gpio_in = 8'h00; tick(3);
        rd_chk(3'd5, 8'h08, "R7 fall despite pol");
        gpio_in = 8'h08; tick(2);
        bus_wr(3'd7, 8'h08);
        rd_chk(3'd5, 8'h08, "R9 event wins over clear");
        bus_wr(3'd7, 8'h08);
        rd_chk(3'd5, 8'h00, "R9 later clear works");

        // R10 edge to level discards latch
        do_reset();
        bus_wr(3'd3, 8'h10);
        gpio_in = 8'h10; tick(3);
        gpio_in = 8'h00; tick(3);
        rd_chk(3'd5, 8'h10, "R10 latched before switch");
        bus_wr(3'd1, 8'h10);
        rd_chk(3'd5, 8'h00, "R10 level inactive");
        bus_wr(3'd1, 8'h00);
        rd_chk(3'd5, 8'h00, "R10 no stale event");

        // R6 multi-line mask
        do_reset();
        bus_wr(3'd3, 8'hFF);
        gpio_in = 8'hC3; tick(3);
        bus_wr(3'd4, 8'h03);
        rd_chk(3'd6, 8'h03, "R6 masked subset");
        irq_chk(1'b1, "R6 irq subset");
        bus_wr(3'd4, 8'h3C);
        rd_chk(3'd6, 8'h00, "R6 masked none");
        irq_chk(1'b0, "R6 irq none");

        tick(2);
        tests++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left exp 0", sbq.size());
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule